// File: doc/BRIEF.md
# Digit-Loop Counter

A synchronous 4-bit state machine that walks a closed loop of decimal digits rather than counting in binary. The loop is taken from a nine-digit identifier given as a parameter. Each digit is kept only where it appears first, later repeats are dropped, and after the last kept digit the counter returns to the first one. Each state is the plain binary code of the digit it stands for.

The loop, its length (one to nine) and the whole next-state map are worked out at elaboration time, so the hardware is one 4-bit register and a fixed 16-way lookup. A synchronous active-high reset loads the first digit. A code outside the loop, including 10 to 15, maps to the first digit on the next edge, so the counter cannot lock up.

Top module: `digit_loop_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `count` takes the first identifier digit after that edge and keeps it for every edge that reset stays high.
- R2: With `rst` low, each rising edge moves `count` to the next entry of the loop, in the order the digits first appear in the identifier.
- R3: A digit that has already appeared earlier in the identifier is skipped and never forms a separate step.
- R4: From the last distinct digit, the next edge returns `count` to the first digit.
- R5: If all nine digits are equal, `count` holds that digit on every edge.
- R6: Nine distinct digits give a loop of length nine, with the ninth digit followed by the first.
- R7: `count` is the 4-bit binary value of the current digit (MSB at bit 3), so it never leaves the set of identifier digits once reset has been applied.
- R8: Raising `rst` partway through the loop restarts it at the first digit on the next edge, and stepping resumes from there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to the first digit |
| count | output | 4 | Binary code of the current digit |

## Verification
Five identifiers are run side by side. 673423451 and 664355644 each contain repeats in scattered places, and either one fails if the deduplication keeps a later copy or loses the order of first occurrence. 777777777 is used to find a counter that moves when its loop has length one. 012345678 checks the full nine-step loop and the wrap from 8 to 0. 909090909 gives a two-entry loop that has 0 as a state, and it shows whether digit zero is treated as a real digit or as padding.

// File: rtl/digit_loop_counter.sv
module digit_loop_counter #(
  parameter int          W  = 4,
  parameter logic [35:0] ID = 36'h673423451
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] count
);
  localparam int N = 9;

  function automatic logic [3:0] nib(input logic [35:0] v, input int i);
    return v[35-4*i -: 4];
  endfunction

  function automatic logic first_seen(input logic [35:0] v, input int i);
    for (int j = 0; j < i; j++)
      if (nib(v, j) == nib(v, i)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int loop_len(input logic [35:0] v);
    int n = 0;
    for (int i = 0; i < N; i++) if (first_seen(v, i)) n++;
    return n;
  endfunction

  function automatic logic [35:0] loop_list(input logic [35:0] v);
    logic [35:0] l = '0;
    int n = 0;
    for (int i = 0; i < N; i++)
      if (first_seen(v, i)) begin
        l[35-4*n -: 4] = nib(v, i);
        n++;
      end
    return l;
  endfunction

  function automatic logic [63:0] next_map(input logic [35:0] v);
    logic [35:0] l = loop_list(v);
    int len = loop_len(v);
    logic [63:0] m = {16{l[35:32]}};
    for (int k = 0; k < len; k++)
      m[4*nib(l, k) +: 4] = nib(l, (k + 1) % len);
    return m;
  endfunction

  localparam logic [3:0]  START = ID[35:32];
  localparam logic [63:0] NEXT  = next_map(ID);

  logic [3:0] nxt;
  assign nxt = NEXT[{count[3:0], 2'b00} +: 4];

  always_ff @(posedge clk)
    if (rst) count <= W'(START);
    else     count <= W'(nxt);
endmodule

module digit_loop_counter_chk #(
  parameter int          W  = 4,
  parameter logic [35:0] ID = 36'h673423451
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] count
);
  function automatic int distinct(input logic [35:0] v);
    logic [15:0] mask = '0;
    int c = 0;
    for (int i = 0; i < 9; i++) mask[v[35-4*i -: 4]] = 1'b1;
    for (int b = 0; b < 16; b++) c += int'(mask[b]);
    return c;
  endfunction

  function automatic logic in_id(input logic [W-1:0] v);
    for (int i = 0; i < 9; i++)
      if (W'(ID[35-4*i -: 4]) == v) return 1'b1;
    return 1'b0;
  endfunction

  localparam int D = distinct(ID);

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | rst;

  assert_reset_first_R1: assert property (@(posedge clk)
    rst |=> count == W'(ID[35:32]));

  assert_member_R7: assert property (@(posedge clk) disable iff (rst || !armed)
    in_id(count));

  generate
    if (D > 1) begin : g_move
      assert_moves_R2: assert property (@(posedge clk) disable iff (!armed)
        !rst |=> count != $past(count));
    end else begin : g_hold
      assert_hold_R5: assert property (@(posedge clk) disable iff (!armed)
        !rst |=> $stable(count));
    end
  endgenerate
endmodule

bind digit_loop_counter digit_loop_counter_chk #(.W(W), .ID(ID)) chk (
  .clk(clk), .rst(rst), .count(count));

// File: tb/digit_loop_counter_test.sv
`timescale 1ns/1ps
module digit_loop_counter_test;
  localparam int N = 5;
  localparam logic [35:0] IDS [N] = '{36'h673423451, 36'h664355644,
                                      36'h777777777, 36'h012345678, 36'h909090909};
  localparam logic [35:0] EXP [N] = '{36'h673425100, 36'h643500000,
                                      36'h700000000, 36'h012345678, 36'h900000000};
  localparam int LEN [N] = '{7, 4, 1, 9, 2};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] cnt [N];
  int runs = 0, fails = 0;
  int idx [N];
  logic done = 1'b0;

  always #5 clk = ~clk;

  for (genvar g = 0; g < N; g++) begin : gi
    digit_loop_counter #(.W(4), .ID(IDS[g])) uut (.clk(clk), .rst(rst), .count(cnt[g]));
  end

  function automatic logic [3:0] exp_at(int g, int k);
    return EXP[g][35-4*k -: 4];
  endfunction

  task automatic check(int g, logic [3:0] act, logic [3:0] exp, string req);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s id=%h act=%0d exp=%0d", req, IDS[g], act, exp);
    end
  endtask

  task automatic step_all();
    @(negedge clk);
    for (int g = 0; g < N; g++) begin
      idx[g] = (idx[g] + 1) % LEN[g];
      if (LEN[g] == 1)      check(g, cnt[g], exp_at(g, idx[g]), "R5");
      else if (idx[g] == 0) check(g, cnt[g], exp_at(g, idx[g]), g == 3 ? "R6" : "R4");
      else if (g == 1 || g == 4) check(g, cnt[g], exp_at(g, idx[g]), "R3");
      else                  check(g, cnt[g], exp_at(g, idx[g]), "R2");
      runs++;
      if (cnt[g] > 4'd9) begin
        fails++;
        $display("FAIL R7 id=%h act=%0d exp<=9", IDS[g], cnt[g]);
      end
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    for (int g = 0; g < N; g++) check(g, cnt[g], exp_at(g, 0), "R1");
    @(negedge clk);
    for (int g = 0; g < N; g++) check(g, cnt[g], exp_at(g, 0), "R1");
    rst = 1'b0;
    for (int g = 0; g < N; g++) idx[g] = 0;
    for (int s = 0; s < 20; s++) step_all();
    rst = 1'b1;
    @(negedge clk);
    for (int g = 0; g < N; g++) begin
      check(g, cnt[g], exp_at(g, 0), "R8");
      idx[g] = 0;
    end
    rst = 1'b0;
    for (int s = 0; s < 5; s++) step_all();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        runs++;
        fails++;
        $display("FAIL watchdog act=running exp=finished");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule